// File: doc/BRIEF.md
# I2C Bus Timing Divider Search Unit

This block turns one number into a complete set of I2C bus timing fields. The number is how many input clocks fit in one SCL period. The block also takes a 3-bit glitch-filter length and a variant flag. It first removes a fixed overhead from the period count: 8 clocks, plus the filter length either once or twice depending on the variant. It then steps through prescaler values from 0 upward. For each one it divides the remaining count by (prescaler + 1) with an iterative divider. It stops at the first quotient that lies strictly between 4 and 512.

From that quotient it derives the SCL low and high times, the start and stop hold and setup times, the data setup and hold times, and the repeated-start release time. All of these are packed into four 32-bit words that a bus engine downstream can load directly. If the count is too small, or no prescaler fits, the block pulses an error and keeps its previous result.

The block is used as a one-shot calculator during bus configuration. The host presents the inputs and pulses `start`. It then waits for either `done` or `err`.

Top module: `scl_timing_search`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low, and `div_out` and all four timing words are zero.
- R2: A `start` pulse while idle captures `ratio_in`, `filt_in` and `filt_once`, and raises `busy` on the next cycle. A `start` while `busy` is high is ignored: the run in progress finishes with the result for the inputs it captured.
- R3: The working count is `ratio_in - 8 - 2*filt_in` when `filt_once` is 0, and `ratio_in - 8 - filt_in` when `filt_once` is 1.
- R4: When `ratio_in` is smaller than the amount to subtract, `err` pulses in the cycle after `start` and `busy` stays low.
- R5: The chosen prescaler `p` is the smallest value in 0..255 for which `q = count/(p+1)` satisfies 4 < q < 512. `p` appears on `div_out` and in `word_c[23:16]`.
- R6: If no prescaler in 0..255 qualifies, `err` pulses for one cycle and `busy` falls in that same cycle. `div_out` and the four words keep their previous values.
- R7: With `cyc = q - 2` and `sl = cyc/2`: SCL high is `word_b[7:0]` and SCL low is `word_b[15:8]`, both equal to `sl`. Stop setup `word_a[15:8]`, start hold `word_a[23:16]` and start setup `word_a[31:24]` also equal `sl`. `word_a[7:0]` is zero.
- R8: Data setup `word_b[31:24]` and data hold `word_d[7:0]` both equal `sl/2`. The repeated-start release `word_c[15:0]` equals `cyc`. All other bits of `word_b`, `word_c` and `word_d` are zero.
- R9: `done` is a one-cycle pulse that coincides with `busy` falling, and `done` and `err` never occur together. The outputs change only in the cycle `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation (ignored while busy) |
| ratio_in | input | 32 | Input clocks per SCL period |
| filt_in | input | 3 | Glitch-filter length in clocks |
| filt_once | input | 1 | 1: subtract filter once; 0: twice |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse: new result valid |
| err | output | 1 | One-cycle pulse: no valid setting |
| div_out | output | 8 | Chosen prescaler |
| word_a | output | 32 | Start setup, start hold, stop setup |
| word_b | output | 32 | Data setup, SCL low, SCL high |
| word_c | output | 32 | Prescaler and repeated-start release |
| word_d | output | 32 | Data hold |

## Verification
The assertions assume that `start` is only a pulse and that the inputs are valid in the cycle `start` is high. They do not assume the inputs stay stable afterwards, because the block captures them. The stimulus changes the inputs only on falling edges. It raises `start` for exactly one cycle, including one deliberate pulse in the middle of a run. It keeps every ratio inside the 32-bit input width, including values at the underflow edge, at the q=511/512 boundary and at the largest count that still fits prescaler 255.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;
  localparam int FLD_W  = 8;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2
  } srch_state_t;

  typedef struct packed {
    logic [WORD_W-1:0] a;
    logic [WORD_W-1:0] b;
    logic [WORD_W-1:0] c;
    logic [WORD_W-1:0] d;
  } timing_words_t;
endpackage

// File: rtl/tdiv_iter_divider.sv
module tdiv_iter_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             vld
);
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_W - 1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DEN_W-1:0] rem_q, rem_d;
  logic [NUM_W-1:0] sh_q, sh_d;
  logic             vld_q, vld_d;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             ge;

  // The shift register starts as the dividend; its top bit moves into the
  // partial remainder each step and the quotient bit enters from below.
  assign trial = {rem_q, sh_q[NUM_W-1]};
  assign ge    = trial >= {1'b0, den};
  assign diff  = trial - {1'b0, den};

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    rem_d = rem_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    if (go) begin
      run_d = 1'b1;
      cnt_d = '0;
      rem_d = '0;
      sh_d  = num;
    end else if (run_q) begin
      rem_d = ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      sh_d  = {sh_q[NUM_W-2:0], ge};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        run_d = 1'b0;
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      run_q <= run_d;
      vld_q <= vld_d;
      if (go || run_q) begin
        cnt_q <= cnt_d;
        rem_q <= rem_d;
        sh_q  <= sh_d;
      end
    end
  end

  assign quo = sh_q;
  assign vld = vld_q;
endmodule

// File: rtl/tdiv_phase_pack.sv
module tdiv_phase_pack
  import tdiv_pkg::*;
#(
  parameter int Q_W   = 32,
  parameter int DIV_W = 8,
  parameter int Q_LO  = 4
) (
  input  logic [Q_W-1:0]   quo,
  input  logic [DIV_W-1:0] div_val,
  output logic             fits,
  output timing_words_t    words
);
  localparam int Q_HI = 2 ** (FLD_W + 1);

  logic [FLD_W:0]   cyc;
  logic [FLD_W-1:0] scl_t;
  logic [FLD_W-1:0] dat_t;

  assign fits  = (quo > Q_W'(Q_LO)) && (quo < Q_W'(Q_HI));
  assign cyc   = quo[FLD_W:0] - (FLD_W+1)'(2);
  assign scl_t = cyc[FLD_W:1];
  assign dat_t = {1'b0, scl_t[FLD_W-1:1]};

  always_comb begin
    words.a = {scl_t, scl_t, scl_t, FLD_W'(0)};
    words.b = {dat_t, FLD_W'(0), scl_t, scl_t};
    words.c = (WORD_W'(div_val) << 16) | WORD_W'(cyc);
    words.d = WORD_W'(dat_t);
  end
endmodule

// File: rtl/scl_timing_search.sv
module scl_timing_search
  import tdiv_pkg::*;
#(
  parameter int RATIO_W = 32,
  parameter int FILT_W  = 3,
  parameter int DIV_W   = 8,
  parameter int Q_LO    = 4,
  parameter int OVH     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic [FILT_W-1:0]  filt_in,
  input  logic               filt_once,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [DIV_W-1:0]   div_out,
  output logic [31:0]        word_a,
  output logic [31:0]        word_b,
  output logic [31:0]        word_c,
  output logic [31:0]        word_d
);
  localparam int DVS_W = DIV_W + 1;
  localparam logic [DIV_W-1:0] DIV_LAST = {DIV_W{1'b1}};

  srch_state_t      state_q, state_d;
  logic [RATIO_W-1:0] base_q, base_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] dout_q, dout_d;
  timing_words_t    words_q, words_d, cand;
  logic             done_q, done_d, err_q, err_d;
  logic             go, fits, quo_vld;
  logic [RATIO_W-1:0] quo;
  logic [RATIO_W-1:0] sub_amt, needed, base_cmb;
  logic             under;
  logic             en_base, en_div, en_res;

  // Overhead removed from the period count before the search starts.
  assign sub_amt  = filt_once ? RATIO_W'(filt_in) : (RATIO_W'(filt_in) << 1);
  assign needed   = RATIO_W'(OVH) + sub_amt;
  assign under    = ratio_in < needed;
  assign base_cmb = ratio_in - needed;

  tdiv_iter_divider #(.NUM_W(RATIO_W), .DEN_W(DVS_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .num   (base_q),
    .den   ({1'b0, div_q} + DVS_W'(1)),
    .quo   (quo),
    .vld   (quo_vld)
  );

  tdiv_phase_pack #(.Q_W(RATIO_W), .DIV_W(DIV_W), .Q_LO(Q_LO)) u_pack (
    .quo     (quo),
    .div_val (div_q),
    .fits    (fits),
    .words   (cand)
  );

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    div_d   = div_q;
    dout_d  = dout_q;
    words_d = words_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    go      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (under) begin
            err_d = 1'b1;
          end else begin
            base_d  = base_cmb;
            div_d   = '0;
            state_d = ST_LAUNCH;
          end
        end
      end
      ST_LAUNCH: begin
        go      = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (quo_vld) begin
          if (fits) begin
            words_d = cand;
            dout_d  = div_q;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (div_q == DIV_LAST) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            div_d   = div_q + 1'b1;
            state_d = ST_LAUNCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign en_base = (state_q == ST_IDLE) && start && !under;
  assign en_div  = en_base || ((state_q == ST_WAIT) && quo_vld);
  assign en_res  = done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      div_q   <= '0;
      dout_q  <= '0;
      words_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (en_base) base_q <= base_d;
      if (en_div)  div_q  <= div_d;
      if (en_res) begin
        dout_q  <= dout_d;
        words_q <= words_d;
      end
    end
  end

  assign busy    = state_q != ST_IDLE;
  assign done    = done_q;
  assign err     = err_q;
  assign div_out = dout_q;
  assign word_a  = words_q.a;
  assign word_b  = words_q.b;
  assign word_c  = words_q.c;
  assign word_d  = words_q.d;
endmodule

// File: rtl/tdiv_search_chk.sv
module tdiv_search_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [DIV_W-1:0] div_out,
  input logic [31:0]      word_a,
  input logic [31:0]      word_b,
  input logic [31:0]      word_c,
  input logic [31:0]      word_d
);
  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_err_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  assert_div_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (word_c[16 +: DIV_W] == div_out) && (word_c[31:16+DIV_W] == '0));

  assert_phase_eq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (word_a[31:24] == word_b[15:8]) && (word_a[23:16] == word_b[15:8])
             && (word_a[15:8] == word_b[15:8]) && (word_b[15:8] == word_b[7:0])
             && (word_a[7:0] == 8'd0));

  assert_data_rel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (word_b[31:24] == word_d[7:0]) && (word_d[7:0] == (word_b[7:0] >> 1))
             && (word_c[8:1] == word_b[7:0]) && (word_c[8:0] >= 9'd3)
             && (word_c[15:9] == 7'd0) && (word_d[31:8] == 24'd0)
             && (word_b[23:16] == 8'd0));

  assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err && !busy && $past(busy));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(word_a) && $stable(word_b) && $stable(word_c)
              && $stable(word_d) && $stable(div_out));
endmodule

bind scl_timing_search tdiv_search_chk #(.DIV_W(DIV_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .div_out (div_out),
  .word_a  (word_a),
  .word_b  (word_b),
  .word_c  (word_c),
  .word_d  (word_d)
);

// File: tb/test_scl_timing_search.sv
`timescale 1ns/1ps
module test_scl_timing_search;
  typedef struct {
    bit          e;
    logic [7:0]  dv;
    logic [31:0] a, b, c, d;
    string       tag;
  } exp_t;

  logic        clk, rst_n, start, filt_once;
  logic [31:0] ratio_in;
  logic [2:0]  filt_in;
  logic        busy, done, err;
  logic [7:0]  div_out;
  logic [31:0] word_a, word_b, word_c, word_d;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;
  exp_t sb[$];
  logic [7:0]  last_dv = 0;
  logic [31:0] last_a = 0, last_b = 0, last_c = 0, last_d = 0;

  scl_timing_search i_scl_timing_search (
    .clk(clk), .rst_n(rst_n), .start(start), .ratio_in(ratio_in),
    .filt_in(filt_in), .filt_once(filt_once), .busy(busy), .done(done),
    .err(err), .div_out(div_out), .word_a(word_a), .word_b(word_b),
    .word_c(word_c), .word_d(word_d));

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Reference from the requirements (R3, R5, R7, R8, R6 keeps old values).
  function automatic exp_t model(input longint r, input int f, input bit once, input string tag);
    exp_t x;
    longint sub, base, q, cyc, sl, dt;
    x.tag = tag; x.e = 1;
    x.dv = last_dv; x.a = last_a; x.b = last_b; x.c = last_c; x.d = last_d;
    sub = once ? f : 2 * f;
    if (r < 8 + sub) return x;
    base = r - 8 - sub;
    for (int p = 0; p < 256; p++) begin
      q = base / (p + 1);
      if (q > 4 && q < 512) begin
        cyc = q - 2; sl = cyc / 2; dt = sl / 2;
        x.e  = 0;
        x.dv = 8'(p);
        x.a  = {8'(sl), 8'(sl), 8'(sl), 8'd0};
        x.b  = {8'(dt), 8'd0, 8'(sl), 8'(sl)};
        x.c  = {8'd0, 8'(p), 16'(cyc)};
        x.d  = 32'(dt);
        last_dv = x.dv; last_a = x.a; last_b = x.b; last_c = x.c; last_d = x.d;
        return x;
      end
    end
    return x;
  endfunction

  // Monitor: pops the scoreboard whenever a result appears.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (done || err)) begin
        if (sb.size() == 0) begin
          check(0, "R2 unexpected result", {done, err}, 0);
        end else begin
          exp_t x;
          x = sb.pop_front();
          check(!(done && err), {"R9 done/err exclusive ", x.tag}, {done, err}, 0);
          check(err == x.e, {"R5/R6 outcome ", x.tag}, err, x.e);
          check(div_out == x.dv, {"R5 div_out ", x.tag}, div_out, x.dv);
          check(word_a == x.a, {"R7 word_a ", x.tag}, word_a, x.a);
          check(word_b == x.b, {"R7/R8 word_b ", x.tag}, word_b, x.b);
          check(word_c == x.c, {"R8 word_c ", x.tag}, word_c, x.c);
          check(word_d == x.d, {"R8 word_d ", x.tag}, word_d, x.d);
          check(!busy, {"R9 busy falls with result ", x.tag}, busy, 0);
        end
      end
    end
  end

  task automatic run(input longint r, input int f, input bit once, input string tag);
    exp_t x;
    bit   uf;
    uf = (r < 8 + (once ? f : 2 * f));
    @(negedge clk);
    x = model(r, f, once, tag);
    sb.push_back(x);
    ratio_in = 32'(r); filt_in = 3'(f); filt_once = once; start = 1;
    @(negedge clk);
    start = 0; ratio_in = '1; filt_in = '1; filt_once = ~once;
    if (uf) begin
      check(busy == 0, {"R4 busy stays low ", tag}, busy, 0);
      check(err == 1, {"R4 immediate err ", tag}, err, 1);
    end else begin
      check(busy == 1, {"R2 busy raised ", tag}, busy, 1);
    end
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_errs++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; ratio_in = 0; filt_in = 0; filt_once = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !err, "R1 reset flags", {busy, done, err}, 0);
    check(word_a == 0 && word_b == 0 && word_c == 0 && word_d == 0 && div_out == 0,
          "R1 reset outputs", word_a | word_b | word_c | word_d, 0);
    rst_n = 1;
    @(negedge clk);

    run(100, 0, 0, "basic p0");
    run(1000, 2, 0, "p1");
    run(300, 7, 0, "R3 filter twice");
    run(300, 7, 1, "R3 filter once");
    run(519, 0, 0, "R5 q=511 at p0");
    run(520, 0, 0, "R5 q=512 moves to p1");
    run(13, 0, 0, "R7 smallest q=5");
    run(21, 7, 0, "R4 underflow");
    run(21, 7, 1, "R3 once no underflow");
    run(7, 0, 0, "R4 underflow by one");
    run(12, 0, 0, "R6 count 4 no fit");
    run(131079, 0, 0, "R5 fits at p255");
    run(131080, 0, 0, "R6 too large");
    run(50000, 3, 1, "mid range");
    run(32'hFFFF_FFFF, 5, 0, "R6 max ratio");

    // R2: a second start during a run is ignored.
    begin
      exp_t x;
      @(negedge clk);
      x = model(40000, 1, 0, "R2 ignored start");
      sb.push_back(x);
      ratio_in = 40000; filt_in = 1; filt_once = 0; start = 1;
      @(negedge clk);
      start = 0;
      repeat (5) @(negedge clk);
      ratio_in = 200; filt_in = 0; start = 1;
      @(negedge clk);
      start = 0;
      while (sb.size() != 0) @(negedge clk);
      repeat (20) @(negedge clk);
      check(busy == 0 && sb.size() == 0, "R2 no second run", busy, 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule